// File: doc/BRIEF.md
# Framed Serial Payload Receiver with Lock Detection

This block takes a serial bit stream in which every frame carries ten payload bits between a high start bit and a low stop bit, twelve bits in all. Bits arrive one per cycle in which the bit-rate enable is high. That enable comes from a local reference and is generated outside the block. While it is not locked, the receiver looks for a low bit followed by a high bit and treats the high bit as a possible frame start. It then checks the stop/start pair at each expected frame boundary. After enough good boundaries it raises its lock flag and, once per frame, places the received payload on a parallel bus.

A parallel-rate strobe goes with the bus. The strobe is high for the first half of each frame, and a polarity input chooses whether the bus changes on the strobe's rising or falling edge. The pads are tri-stated outside the block, so high impedance is expressed as three drive-enable outputs. A sleep input turns off every enable and drops lock. An output-enable input turns off only the payload and strobe enables, so the lock flag can still be read. Lock is regained by sending all-zero payload frames, because in such frames the only low-to-high transition is the true frame start.

Top module: `efd_rx`

## Requirements
- R1: A frame is sent as bit slot 0 = start (1), slots 1..10 = payload bits 0..9 (payload bit 0 arrives first), slot 11 = stop (0). The presented payload keeps that bit numbering.
- R2: While hunting, a received 1 whose preceding received bit was 0 is taken as a candidate start at slot 0.
- R3: `lock_o` rises only at a boundary check that passes. A boundary check is made on the bit that follows slot 11, and it passes when slot 11 was 0 and the new bit is 1. Two consecutive passing checks after a candidate set lock.
- R4: A failing boundary check, whether checking or locked, clears `lock_o` on the same edge and restarts hunting.
- R5: `pdata_o` changes at most once per frame and only while locked. Otherwise it keeps its last value (0 after reset).
- R6: `rclk_o` is 1 while locked and the current slot is 0..5. It is 0 otherwise.
- R7: With `edge_sel`=0, the completed payload appears on the edge that accepts the next start bit, together with the rise of `rclk_o`. With `edge_sel`=1, it appears on the edge that moves into slot 6, together with the fall of `rclk_o`.
- R8: While `sleep`=1, all three drive enables are 0, lock is cleared and received bits are ignored.
- R9: While `out_en`=0 and not asleep, `data_oe` and `rclk_oe` are 0, `lock_oe` is 1, and framing and lock go on as normal.
- R10: After lock is lost, three all-zero payload frames (one candidate followed by two boundaries) restore lock.
- R11: In a cycle with `bit_en`=0 and `sleep`=0, no output changes on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Bit-rate enable; one serial bit accepted per high cycle |
| ser_in | input | 1 | Serial data bit |
| edge_sel | input | 1 | 0: bus changes with strobe rise; 1: with strobe fall |
| sleep | input | 1 | Power-down: all enables off, lock cleared |
| out_en | input | 1 | Enables the payload and strobe pad drivers |
| pdata_o | output | PAY_W | Parallel payload |
| rclk_o | output | 1 | Recovered parallel-rate strobe |
| lock_o | output | 1 | Frame lock status |
| data_oe | output | 1 | Drive enable for the payload pads |
| rclk_oe | output | 1 | Drive enable for the strobe pad |
| lock_oe | output | 1 | Drive enable for the lock pad |

## Verification
The assertions assume that `ser_in`, `bit_en` and the control inputs change only between clock edges and stay constant through each cycle. The stimulus drives them one time unit after a rising edge. The lock and stability properties also assume that any frame error shows up at a boundary check and not in the payload slots. The stimulus therefore corrupts only the stop bit, and it sends all-zero frames whenever it expects lock to be regained. The polarity input is changed only at frame boundaries, so every payload reaches the bus exactly once.

// File: rtl/efd_pkg.sv
package efd_pkg;
  typedef enum logic [1:0] {
    ST_HUNT  = 2'd0,
    ST_CHECK = 2'd1,
    ST_LOCK  = 2'd2
  } efd_state_e;
endpackage

// File: rtl/efd_framer.sv
module efd_framer
  import efd_pkg::*;
#(
  parameter int PAY_W       = 10,
  parameter int LOCK_FRAMES = 2,
  localparam int FRAME_W    = PAY_W + 2,
  localparam int PW         = $clog2(FRAME_W),
  localparam int GW         = $clog2(LOCK_FRAMES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             ser_in,
  input  logic             sleep,
  output efd_state_e       state,
  output logic [PW-1:0]    pos,
  output logic             cand_hit,
  output logic             bnd_ok,
  output logic             bnd_bad,
  output logic [PAY_W-1:0] payload
);
  localparam logic [PW-1:0] LAST = PW'(FRAME_W - 1);

  logic [PAY_W:0] sh;
  logic [GW-1:0]  good;
  logic           active, bnd_chk;

  function automatic logic [PW-1:0] step_pos(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  // sh[0] holds the stop slot, sh[PAY_W] the first payload bit received
  function automatic logic [PAY_W-1:0] unpack(input logic [PAY_W:0] s);
    logic [PAY_W-1:0] r;
    for (int i = 0; i < PAY_W; i++) r[i] = s[PAY_W - i];
    return r;
  endfunction

  assign active   = bit_en && !sleep;
  assign cand_hit = active && (state == ST_HUNT) && !sh[0] && ser_in;
  assign bnd_chk  = active && (state != ST_HUNT) && (pos == LAST);
  assign bnd_ok   = bnd_chk && !sh[0] && ser_in;
  assign bnd_bad  = bnd_chk && !bnd_ok;
  assign payload  = unpack(sh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_HUNT;
      pos   <= '0;
      good  <= '0;
      sh    <= '0;
    end else if (sleep) begin
      state <= ST_HUNT;
      pos   <= '0;
      good  <= '0;
    end else if (bit_en) begin
      sh <= {sh[PAY_W-1:0], ser_in};
      unique case (state)
        ST_HUNT: if (cand_hit) begin
          state <= ST_CHECK;
          pos   <= '0;
          good  <= '0;
        end
        default: begin
          pos <= step_pos(pos);
          if (bnd_bad) begin
            state <= ST_HUNT;
          end else if (bnd_ok && state == ST_CHECK) begin
            if (good == GW'(LOCK_FRAMES - 1)) state <= ST_LOCK;
            else                              good  <= good + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/efd_outstage.sv
module efd_outstage #(
  parameter int PAY_W    = 10,
  localparam int FRAME_W = PAY_W + 2,
  localparam int PW      = $clog2(FRAME_W),
  localparam int HALF    = FRAME_W / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             edge_sel,
  input  logic             locked,
  input  logic [PW-1:0]    pos,
  input  logic             bnd_ok,
  input  logic [PAY_W-1:0] payload,
  output logic [PAY_W-1:0] pdata,
  output logic             rclk,
  output logic             fall_evt
);
  logic [PAY_W-1:0] stage;
  logic             stvld;
  logic             cap_evt;

  assign cap_evt  = bnd_ok && locked;
  assign fall_evt = active && locked && (pos == PW'(HALF - 1));
  assign rclk     = locked && (pos < PW'(HALF));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pdata <= '0;
      stage <= '0;
      stvld <= 1'b0;
    end else if (!locked) begin
      stvld <= 1'b0;
    end else if (cap_evt) begin
      if (!edge_sel) pdata <= payload;
      else begin
        stage <= payload;
        stvld <= 1'b1;
      end
    end else if (fall_evt && edge_sel && stvld) begin
      pdata <= stage;
      stvld <= 1'b0;
    end
  end
endmodule

// File: rtl/efd_padctl.sv
module efd_padctl (
  input  logic sleep,
  input  logic out_en,
  output logic data_oe,
  output logic rclk_oe,
  output logic lock_oe
);
  assign lock_oe = !sleep;
  assign data_oe = !sleep && out_en;
  assign rclk_oe = !sleep && out_en;
endmodule

// File: rtl/efd_rx.sv
module efd_rx
  import efd_pkg::*;
#(
  parameter int PAY_W       = 10,
  parameter int LOCK_FRAMES = 2,
  localparam int FRAME_W    = PAY_W + 2,
  localparam int PW         = $clog2(FRAME_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             ser_in,
  input  logic             edge_sel,
  input  logic             sleep,
  input  logic             out_en,
  output logic [PAY_W-1:0] pdata_o,
  output logic             rclk_o,
  output logic             lock_o,
  output logic             data_oe,
  output logic             rclk_oe,
  output logic             lock_oe
);
  efd_state_e       state;
  logic [PW-1:0]    frame_pos;
  logic             cand_hit, bnd_ok, bnd_bad, fall_evt;
  logic [PAY_W-1:0] payload;

  efd_framer #(.PAY_W(PAY_W), .LOCK_FRAMES(LOCK_FRAMES)) u_framer (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .ser_in(ser_in), .sleep(sleep),
    .state(state), .pos(frame_pos), .cand_hit(cand_hit),
    .bnd_ok(bnd_ok), .bnd_bad(bnd_bad), .payload(payload)
  );

  assign lock_o = (state == ST_LOCK);

  efd_outstage #(.PAY_W(PAY_W)) u_out (
    .clk(clk), .rst_n(rst_n), .active(bit_en && !sleep), .edge_sel(edge_sel),
    .locked(lock_o), .pos(frame_pos), .bnd_ok(bnd_ok), .payload(payload),
    .pdata(pdata_o), .rclk(rclk_o), .fall_evt(fall_evt)
  );

  efd_padctl u_pad (
    .sleep(sleep), .out_en(out_en),
    .data_oe(data_oe), .rclk_oe(rclk_oe), .lock_oe(lock_oe)
  );
endmodule

// File: rtl/efd_rx_chk.sv
module efd_rx_chk #(
  parameter int PAY_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_en,
  input logic             sleep,
  input logic             out_en,
  input logic [PAY_W-1:0] pdata_o,
  input logic             rclk_o,
  input logic             lock_o,
  input logic             data_oe,
  input logic             rclk_oe,
  input logic             lock_oe,
  input logic             cand_hit,
  input logic             bnd_ok,
  input logic             bnd_bad
);
  a_r3_lock_from_good_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> $past(bnd_ok));

  a_r2_candidate_not_locked: assert property (@(posedge clk) disable iff (!rst_n)
    cand_hit |-> !lock_o);

  a_r4_bad_boundary_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    bnd_bad |=> !lock_o);

  a_r5_hold_while_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_o && !$past(lock_o)) |-> $stable(pdata_o));

  a_r6_strobe_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    rclk_o |-> lock_o);

  a_r8_sleep_drops_lock: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !lock_o);

  a_r8_sleep_pads_off: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (!lock_oe && !data_oe && !rclk_oe));

  a_r9_lock_pad_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_en && !sleep) |-> (lock_oe && !data_oe && !rclk_oe));

  a_r11_idle_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_en && !sleep) |=> ($stable(lock_o) && $stable(pdata_o) && $stable(rclk_o)));
endmodule

bind efd_rx efd_rx_chk #(.PAY_W(PAY_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .sleep(sleep), .out_en(out_en),
  .pdata_o(pdata_o), .rclk_o(rclk_o), .lock_o(lock_o), .data_oe(data_oe),
  .rclk_oe(rclk_oe), .lock_oe(lock_oe), .cand_hit(cand_hit),
  .bnd_ok(bnd_ok), .bnd_bad(bnd_bad)
);

// File: tb/sim_efd_rx.sv
module sim_efd_rx;
  localparam int CLK_P = 10;
  localparam int PW    = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0, ser_in = 1'b0, edge_sel = 1'b0, sleep = 1'b0, out_en = 1'b1;
  logic [PW-1:0] pdata_o;
  logic rclk_o, lock_o, data_oe, rclk_oe, lock_oe;

  int n_chk = 0, n_fail = 0, gap = 2;
  bit done = 1'b0, cmp_on = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  efd_rx u0 (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .ser_in(ser_in), .edge_sel(edge_sel),
    .sleep(sleep), .out_en(out_en), .pdata_o(pdata_o), .rclk_o(rclk_o),
    .lock_o(lock_o), .data_oe(data_oe), .rclk_oe(rclk_oe), .lock_oe(lock_oe)
  );

  // behavioural reference: 0 hunt, 1 checking, 2 locked
  int     m_st = 0, m_good = 0;
  bit     m_last = 1'b0, m_stv = 1'b0;
  bit     m_q[$];
  logic [PW-1:0] m_data = '0, m_stage = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_good = 0; m_last = 0; m_stv = 0; m_q.delete();
      m_data = '0; m_stage = '0;
    end else if (sleep) begin
      m_st = 0; m_good = 0; m_stv = 0; m_q.delete();
    end else if (bit_en) begin
      if (m_st == 0) begin
        if (!m_last && ser_in) begin
          m_st = 1; m_good = 0; m_q.delete(); m_q.push_back(1'b1);
        end
      end else if (m_q.size() == PW + 2) begin
        if (!m_q[PW+1] && ser_in) begin
          logic [PW-1:0] pl;
          for (int i = 0; i < PW; i++) pl[i] = m_q[1+i];
          if (m_st == 1) begin
            m_good++;
            if (m_good == 2) m_st = 2;
          end else if (!edge_sel) m_data = pl;
          else begin
            m_stage = pl; m_stv = 1;
          end
          m_q.delete(); m_q.push_back(1'b1);
        end else begin
          m_st = 0; m_q.delete(); m_stv = 0;
        end
      end else begin
        m_q.push_back(ser_in);
        if (m_st == 2 && m_q.size() == 7 && edge_sel && m_stv) begin
          m_data = m_stage; m_stv = 0;
        end
      end
      m_last = ser_in;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // every-cycle comparison away from the edge
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      bit e_lock, e_rclk;
      e_lock = (m_st == 2);
      e_rclk = e_lock && (m_q.size() >= 1) && (m_q.size() <= 6);
      check(lock_o == e_lock, "R3", "lock_o", lock_o, e_lock);
      check(pdata_o == m_data, "R5", "pdata_o", pdata_o, m_data);
      check(rclk_o == e_rclk, "R6", "rclk_o", rclk_o, e_rclk);
      check(lock_oe == !sleep, "R8", "lock_oe", lock_oe, !sleep);
      check(data_oe == (!sleep && out_en), "R9", "data_oe", data_oe, !sleep && out_en);
      check(rclk_oe == (!sleep && out_en), "R9", "rclk_oe", rclk_oe, !sleep && out_en);
    end
  end

  task automatic send_bit(input bit b);
    ser_in = b; bit_en = 1'b1;
    @(posedge clk); #1;
    bit_en = 1'b0;
    for (int k = 0; k < gap; k++) begin @(posedge clk); #1; end
  endtask

  task automatic send_slots(input logic [PW-1:0] pl, input bit stopv,
                            input int from, input int to);
    for (int s = from; s <= to; s++) begin
      if (s == 0)       send_bit(1'b1);
      else if (s <= PW) send_bit(pl[s-1]);
      else              send_bit(stopv);
    end
  endtask

  task automatic send_frame(input logic [PW-1:0] pl);
    send_slots(pl, 1'b0, 0, PW + 1);
  endtask

  task automatic train();
    for (int f = 0; f < 3; f++) send_frame('0);
  endtask

  initial begin
    logic [PW-1:0] held;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    cmp_on = 1'b1;
    @(negedge clk);
    // reset state
    check(lock_o == 0, "R3", "reset lock", lock_o, 0);
    check(pdata_o == 0, "R5", "reset data", pdata_o, 0);
    check(rclk_o == 0, "R6", "reset strobe", rclk_o, 0);
    @(posedge clk); #1;

    // R2/R3: idle low then zero frames
    for (int k = 0; k < 5; k++) send_bit(1'b0);
    send_frame('0); send_frame('0);
    check(lock_o == 0, "R3", "after one boundary", lock_o, 0);
    send_frame('0);
    check(lock_o == 1, "R2", "lock after candidate+2 boundaries", lock_o, 1);

    // R1/R7 rise polarity: payload shown after next start bit
    send_frame(10'h2A5);
    send_slots(10'h013, 1'b0, 0, 0);
    check(pdata_o == 10'h2A5, "R1", "payload bit order", pdata_o, 10'h2A5);
    check(rclk_o == 1, "R7", "strobe high with new data", rclk_o, 1);
    send_slots(10'h013, 1'b0, 1, PW + 1);
    for (int f = 0; f < 6; f++) begin
      gap = 1 + (f % 3);
      send_frame(10'((f * 151 + 37) % 1024));
    end
    gap = 2;

    // R11: stall mid-frame
    send_slots(10'h155, 1'b0, 0, 4);
    held = pdata_o;
    repeat (15) @(posedge clk);
    #1;
    check(pdata_o == held && lock_o == 1, "R11", "stall holds", pdata_o, held);
    send_slots(10'h155, 1'b0, 5, PW + 1);

    // R7 falling polarity, switched at a boundary
    edge_sel = 1'b1;
    send_frame(10'h0F0);
    held = pdata_o;
    send_slots(10'h300, 1'b0, 0, 4);
    check(pdata_o == held, "R7", "no change before strobe fall", pdata_o, held);
    send_slots(10'h300, 1'b0, 5, 6);
    check(pdata_o == 10'h0F0, "R7", "change at strobe fall", pdata_o, 10'h0F0);
    send_slots(10'h300, 1'b0, 7, PW + 1);
    send_frame(10'h0AB);

    // R9: output disable keeps lock working
    out_en = 1'b0;
    send_frame(10'h111); send_frame(10'h222);
    check(lock_oe == 1 && lock_o == 1, "R9", "lock visible", lock_o, 1);
    check(data_oe == 0, "R9", "data pads off", data_oe, 0);
    out_en = 1'b1;
    edge_sel = 1'b0;

    // R4: bad stop bit
    send_slots(10'h3C3, 1'b1, 0, PW + 1);
    send_slots('0, 1'b0, 0, 0);
    check(lock_o == 0, "R4", "lost on bad stop", lock_o, 0);
    held = pdata_o;
    send_slots('0, 1'b0, 1, PW + 1);
    check(pdata_o == held, "R5", "held while unlocked", pdata_o, held);

    // R10: retrain
    train();
    check(lock_o == 1, "R10", "relock with zero frames", lock_o, 1);
    send_frame(10'h1E1);

    // R8: sleep
    sleep = 1'b1;
    send_frame(10'h3FF);
    check(lock_o == 0 && lock_oe == 0 && data_oe == 0 && rclk_oe == 0,
          "R8", "sleep all off", {lock_o, lock_oe, data_oe, rclk_oe}, 0);
    sleep = 1'b0;
    send_bit(1'b0);
    train();
    check(lock_o == 1, "R10", "relock after sleep", lock_o, 1);
    send_frame(10'h2C4); send_frame('0);
    check(pdata_o == 10'h2C4, "R1", "payload after sleep", pdata_o, 10'h2C4);

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule